// File: doc/BRIEF.md
# UART Automatic Modem Handshake Controller

This block sits between a UART transmitter, the receive FIFO and the modem-control pins, and runs hardware handshaking without software involvement. The incoming stop request (active-low, so a high level means "stop") is synchronised and, when enabled, holds off the local transmitter. A character that is already on the line is always completed. The driven request output is pulled inactive when the receive FIFO fills past a high watermark. It becomes active again only after the level drains to a low watermark, which gives the output hysteresis.

A single pair-select bit routes the same logic to either the RTS/CTS pair or the DTR/DSR pair. The pin that is not selected simply follows its manual software bit. Automatic control of the request output is armed only once software has set the selected output bit while the feature is enabled. Two flags record handshake events: a rise on the monitored input, and a rise (deassertion) of the driven output. Each flag sits behind a master enable plus its own per-source enable. Either status-read strobe clears both flags.

Top module: `uart_autoflow`

## Requirements
- R1: After reset, tx_allow is 1, flag_hold, flag_req and irq are 0, and with sw_rts and sw_dtr at 0 both rts_n_out and dtr_n_out are 1.
- R2: With cfg_auto_req_en at 0, rts_n_out equals the inverse of sw_rts and dtr_n_out equals the inverse of sw_dtr, combinationally.
- R3: With cfg_auto_hold_en at 1 and no character in progress, tx_allow becomes 0 three clock edges after the selected monitored input goes high. It returns to 1 three edges after that input goes low. With cfg_auto_hold_en at 0, tx_allow stays 1.
- R4: A tx_start pulse marks a character in progress until tx_stop_done. During that time tx_allow does not change. At the edge that samples tx_stop_done, tx_allow takes the current hold decision. tx_start is only given while tx_allow is 1 and no character is in progress.
- R5: cfg_pair_sel = 0 makes cts_n_in the monitored input and rts_n_out the controlled output. cfg_pair_sel = 1 selects dsr_n_in and dtr_n_out. The input of the unselected pair has no effect on any output.
- R6: Automatic request control is armed at the first edge where cfg_auto_req_en is 1 and the selected software output bit is 1. It is disarmed at any edge where cfg_auto_req_en is 0.
- R7: An internal pause state is set at an edge where rx_level >= thr_hi and cleared at an edge where rx_level <= thr_lo; otherwise it holds. While armed and paused, the selected output is 1 even if its software bit is 1. thr_lo is always below thr_hi.
- R8: When cfg_irq_master_en and cfg_irq_hold_en are both 1, a low-to-high change of the synchronised monitored input sets flag_hold at the next edge.
- R9: When cfg_irq_master_en and cfg_irq_req_en are both 1, a low-to-high change of the selected driven output sets flag_req at the next edge.
- R10: A pulse on isr_rd or msr_rd clears both flags at the next edge, unless a set event for that flag occurs in the same cycle, in which case the set wins.
- R11: irq is 1 exactly when cfg_irq_master_en is 1 and at least one flag is 1 together with its own enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_auto_hold_en | input | 1 | Enable automatic transmit hold from the monitored input |
| cfg_auto_req_en | input | 1 | Enable automatic request-output control |
| cfg_pair_sel | input | 1 | 0: RTS/CTS pair, 1: DTR/DSR pair |
| cfg_irq_master_en | input | 1 | Master enable for both handshake flags |
| cfg_irq_hold_en | input | 1 | Per-source enable for the monitored-input flag |
| cfg_irq_req_en | input | 1 | Per-source enable for the driven-output flag |
| sw_rts | input | 1 | Software RTS level, 1 = active (pin low) |
| sw_dtr | input | 1 | Software DTR level, 1 = active (pin low) |
| cts_n_in | input | 1 | CTS pin, active low, asynchronous |
| dsr_n_in | input | 1 | DSR pin, active low, asynchronous |
| rts_n_out | output | 1 | RTS pin, active low |
| dtr_n_out | output | 1 | DTR pin, active low |
| rx_level | input | LVL_W | Receive FIFO fill level |
| thr_hi | input | LVL_W | Level at which the pause is set |
| thr_lo | input | LVL_W | Level at which the pause is cleared |
| tx_start | input | 1 | Transmitter begins a character |
| tx_stop_done | input | 1 | Stop bit of the current character has left |
| tx_allow | output | 1 | Transmitter may begin a new character |
| isr_rd | input | 1 | Interrupt-status read strobe |
| msr_rd | input | 1 | Modem-status read strobe |
| flag_hold | output | 1 | Monitored input rose |
| flag_req | output | 1 | Driven output deasserted |
| irq | output | 1 | Combined handshake interrupt |

## Verification
The assertions assume that the transmitter behaves: it pulses tx_start only while tx_allow is 1 and no character is in flight, and it gives tx_stop_done only while a character is in flight. They also assume the low watermark is always strictly below the high one. The random stimulus keeps to these rules by deciding start and done pulses from the bench's own model of the in-flight state and the allow output, and by drawing thr_lo below thr_hi each time the thresholds change. Pin levels, enables, pair select and read strobes are random without constraint.

// File: rtl/uart_afc_pkg.sv
package uart_afc_pkg;
  typedef enum logic {
    PAIR_RTS_CTS = 1'b0,
    PAIR_DTR_DSR = 1'b1
  } pair_e;

  typedef struct packed {
    logic master;
    logic hold_en;
    logic req_en;
  } irq_cfg_t;
endpackage

// File: rtl/afc_sync.sv
module afc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  // Pins idle high, so the chain resets high to avoid a false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '1;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/afc_txgate.sv
module afc_txgate (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hold,
  input  logic tx_start,
  input  logic tx_stop_done,
  output logic tx_allow
);
  logic busy_q, busy_d;
  logic hold_q, hold_d;
  logic upd;

  always_comb begin
    busy_d = busy_q;
    if (tx_start)     busy_d = 1'b1;
    if (tx_stop_done) busy_d = 1'b0;
    upd    = !busy_q || tx_stop_done;
    hold_d = upd ? want_hold : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (upd) hold_q <= hold_d;
    end
  end

  assign tx_allow = ~hold_q;

  // R4: starts come only from an idle, allowed transmitter
  assert_start_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_allow && !busy_q));
  // R4: no gating change while a character is on the line
  assert_allow_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tx_stop_done) |=> $stable(tx_allow));
  // R4: done only during a character
  assert_done_in_char_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop_done |-> busy_q);
endmodule

// File: rtl/afc_reqctl.sv
module afc_reqctl #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             sw_sel,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  output logic             pause
);
  logic armed_q, armed_d;
  logic block_q, block_d;

  always_comb begin
    armed_d = auto_en && (armed_q || sw_sel);
    block_d = block_q;
    if (rx_level >= thr_hi)      block_d = 1'b1;
    else if (rx_level <= thr_lo) block_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      block_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      block_q <= block_d;
    end
  end

  assign pause = auto_en && armed_q && block_q;

  // R7: watermarks are ordered
  assert_thr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    thr_lo < thr_hi);
  // R7: high watermark reached and armed gives a pause next cycle
  assert_hi_pauses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= thr_hi && auto_en && armed_q && $stable(auto_en)) |=> (pause || !auto_en));
  // R6: disabling disarms
  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !armed_q);
endmodule

// File: rtl/afc_irq.sv
module afc_irq
  import uart_afc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_cfg_t cfg,
  input  logic     mon_rise,
  input  logic     req_rise,
  input  logic     isr_rd,
  input  logic     msr_rd,
  output logic     flag_hold,
  output logic     flag_req,
  output logic     irq
);
  logic fh_q, fh_d, fr_q, fr_d;
  logic set_h, set_r, clr;

  always_comb begin
    set_h = mon_rise && cfg.master && cfg.hold_en;
    set_r = req_rise && cfg.master && cfg.req_en;
    clr   = isr_rd || msr_rd;
    fh_d  = set_h ? 1'b1 : (clr ? 1'b0 : fh_q);
    fr_d  = set_r ? 1'b1 : (clr ? 1'b0 : fr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fh_q <= 1'b0;
      fr_q <= 1'b0;
    end else begin
      fh_q <= fh_d;
      fr_q <= fr_d;
    end
  end

  assign flag_hold = fh_q;
  assign flag_req  = fr_q;
  assign irq = cfg.master && ((fh_q && cfg.hold_en) || (fr_q && cfg.req_en));

  // R8: an enabled rise is recorded
  assert_hold_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_rise && cfg.master && cfg.hold_en) |=> flag_hold);
  // R10: a read without a new event empties the flags
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_rd || msr_rd) && !mon_rise && !req_rise) |=> (!flag_hold && !flag_req));
  // R11: interrupt needs a pending flag
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_hold || flag_req));
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
  import uart_afc_pkg::*;
#(
  parameter int LVL_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_auto_hold_en,
  input  logic             cfg_auto_req_en,
  input  logic             cfg_pair_sel,
  input  logic             cfg_irq_master_en,
  input  logic             cfg_irq_hold_en,
  input  logic             cfg_irq_req_en,
  input  logic             sw_rts,
  input  logic             sw_dtr,
  input  logic             cts_n_in,
  input  logic             dsr_n_in,
  output logic             rts_n_out,
  output logic             dtr_n_out,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  input  logic             tx_start,
  input  logic             tx_stop_done,
  output logic             tx_allow,
  input  logic             isr_rd,
  input  logic             msr_rd,
  output logic             flag_hold,
  output logic             flag_req,
  output logic             irq
);
  localparam int NPIN = 2;

  pair_e          pair;
  logic [NPIN-1:0] pins_s;
  logic           mon, mon_prev_q;
  logic           sw_sel, pause, sel_pin_n, req_prev_q;
  logic           mon_rise, req_rise;
  irq_cfg_t       icfg;

  assign pair = pair_e'(cfg_pair_sel);

  afc_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dsr_n_in, cts_n_in}), .q(pins_s)
  );

  always_comb begin
    mon       = (pair == PAIR_DTR_DSR) ? pins_s[1] : pins_s[0];
    sw_sel    = (pair == PAIR_DTR_DSR) ? sw_dtr : sw_rts;
    sel_pin_n = ~(sw_sel && !pause);
    rts_n_out = (pair == PAIR_RTS_CTS) ? sel_pin_n : ~sw_rts;
    dtr_n_out = (pair == PAIR_DTR_DSR) ? sel_pin_n : ~sw_dtr;
    mon_rise  = mon && !mon_prev_q;
    req_rise  = sel_pin_n && !req_prev_q;
    icfg      = '{master: cfg_irq_master_en, hold_en: cfg_irq_hold_en,
                  req_en: cfg_irq_req_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_prev_q <= 1'b1;
      req_prev_q <= 1'b1;
    end else begin
      mon_prev_q <= mon;
      req_prev_q <= sel_pin_n;
    end
  end

  afc_txgate u_txgate (
    .clk(clk), .rst_n(rst_n), .want_hold(cfg_auto_hold_en && mon),
    .tx_start(tx_start), .tx_stop_done(tx_stop_done), .tx_allow(tx_allow)
  );

  afc_reqctl #(.LVL_W(LVL_W)) u_reqctl (
    .clk(clk), .rst_n(rst_n), .auto_en(cfg_auto_req_en), .sw_sel(sw_sel),
    .rx_level(rx_level), .thr_hi(thr_hi), .thr_lo(thr_lo), .pause(pause)
  );

  afc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .cfg(icfg), .mon_rise(mon_rise),
    .req_rise(req_rise), .isr_rd(isr_rd), .msr_rd(msr_rd),
    .flag_hold(flag_hold), .flag_req(flag_req), .irq(irq)
  );

  // R2: with automatic control off the pins mirror software
  assert_manual_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_auto_req_en |-> (rts_n_out != sw_rts && dtr_n_out != sw_dtr));
  // R3: hold disabled keeps the transmitter free once idle
  assert_no_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_auto_hold_en && $past(!cfg_auto_hold_en) && tx_allow) |=> (tx_allow || cfg_auto_hold_en));
endmodule

// File: tb/uart_autoflow_bench.sv
module uart_autoflow_bench;
  localparam int LVL_W = 6;
  localparam int MAXL  = (1 << LVL_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_auto_hold_en = 0, cfg_auto_req_en = 0, cfg_pair_sel = 0;
  logic cfg_irq_master_en = 0, cfg_irq_hold_en = 0, cfg_irq_req_en = 0;
  logic sw_rts = 0, sw_dtr = 0, cts_n_in = 0, dsr_n_in = 0;
  logic [LVL_W-1:0] rx_level = '0, thr_hi = LVL_W'(48), thr_lo = LVL_W'(16);
  logic tx_start = 0, tx_stop_done = 0, isr_rd = 0, msr_rd = 0;
  logic rts_n_out, dtr_n_out, tx_allow, flag_hold, flag_req, irq;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  uart_autoflow #(.LVL_W(LVL_W)) u_uart_autoflow (.*);

  // Bench model of the requirements
  logic m_c1, m_c2, m_d1, m_d2, m_monp, m_hold, m_busy, m_armed, m_block, m_reqp, m_fh, m_fr;

  function automatic logic f_mon();
    return cfg_pair_sel ? m_d2 : m_c2;
  endfunction
  function automatic logic f_selpin();
    logic sw, p;
    sw = cfg_pair_sel ? sw_dtr : sw_rts;
    p  = cfg_auto_req_en && m_armed && m_block;
    return !(sw && !p);
  endfunction
  function automatic logic f_rts();
    return cfg_pair_sel ? !sw_rts : f_selpin();
  endfunction
  function automatic logic f_dtr();
    return cfg_pair_sel ? f_selpin() : !sw_dtr;
  endfunction
  function automatic logic f_irq();
    return cfg_irq_master_en && ((m_fh && cfg_irq_hold_en) || (m_fr && cfg_irq_req_en));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c1 = 1; m_c2 = 1; m_d1 = 1; m_d2 = 1; m_monp = 1; m_hold = 0; m_busy = 0;
      m_armed = 0; m_block = 0; m_reqp = 1; m_fh = 0; m_fr = 0;
    end else begin
      logic mon, selp, swsel, sh, sr, clr, nh, nb, na, nbl;
      mon   = f_mon();
      selp  = f_selpin();
      swsel = cfg_pair_sel ? sw_dtr : sw_rts;
      sh    = mon && !m_monp && cfg_irq_master_en && cfg_irq_hold_en;
      sr    = selp && !m_reqp && cfg_irq_master_en && cfg_irq_req_en;
      clr   = isr_rd || msr_rd;
      nh    = (!m_busy || tx_stop_done) ? (cfg_auto_hold_en && mon) : m_hold;
      nb    = tx_stop_done ? 1'b0 : (tx_start ? 1'b1 : m_busy);
      na    = cfg_auto_req_en && (m_armed || swsel);
      nbl   = (rx_level >= thr_hi) ? 1'b1 : ((rx_level <= thr_lo) ? 1'b0 : m_block);
      m_fh  = sh ? 1'b1 : (clr ? 1'b0 : m_fh);
      m_fr  = sr ? 1'b1 : (clr ? 1'b0 : m_fr);
      m_c2 = m_c1; m_c1 = cts_n_in; m_d2 = m_d1; m_d1 = dsr_n_in;
      m_monp = mon; m_reqp = selp; m_hold = nh; m_busy = nb; m_armed = na; m_block = nbl;
    end
  end

  task automatic cmp(input string tag);
    logic ok;
    n_vec++;
    ok = (tx_allow === !m_hold) && (rts_n_out === f_rts()) && (dtr_n_out === f_dtr()) &&
         (flag_hold === m_fh) && (flag_req === m_fr) && (irq === f_irq());
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: allow/rts/dtr/fh/fr/irq got %b%b%b%b%b%b expected %b%b%b%b%b%b",
               tag, tx_allow, rts_n_out, dtr_n_out, flag_hold, flag_req, irq,
               !m_hold, f_rts(), f_dtr(), m_fh, m_fr, f_irq());
    end
  endtask

  task automatic lit(input string tag, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(tag);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    lit("R1 allow", tx_allow, 1'b1);
    lit("R1 rts", rts_n_out, 1'b1);
    lit("R1 dtr", dtr_n_out, 1'b1);
    lit("R1 irq", irq, 1'b0);
    lit("R1 flag", flag_hold | flag_req, 1'b0);

    // R2 manual pins
    sw_rts = 1; step("R2", 1);
    lit("R2 rts", rts_n_out, 1'b0);
    sw_dtr = 1; sw_rts = 0; step("R2", 1);
    lit("R2 dtr", dtr_n_out, 1'b0);
    lit("R2 rts", rts_n_out, 1'b1);
    sw_dtr = 0;

    // R3 hold when idle
    cts_n_in = 1; step("R3 off", 4);
    lit("R3 disabled", tx_allow, 1'b1);
    cts_n_in = 0; step("R3", 4);
    cfg_auto_hold_en = 1; cts_n_in = 1; step("R3", 2);
    lit("R3 not yet", tx_allow, 1'b1);
    step("R3", 1);
    lit("R3 held", tx_allow, 1'b0);
    cts_n_in = 0; step("R3", 3);
    lit("R3 released", tx_allow, 1'b1);

    // R4 character boundary
    tx_start = 1; step("R4", 1);
    tx_start = 0; cts_n_in = 1; step("R4", 5);
    lit("R4 in char", tx_allow, 1'b1);
    tx_stop_done = 1; step("R4", 1);
    tx_stop_done = 0;
    lit("R4 after stop", tx_allow, 1'b0);
    cts_n_in = 0; step("R4", 4);

    // R5 pair select: CTS ignored when DSR selected
    cfg_pair_sel = 1; cts_n_in = 1; step("R5", 4);
    lit("R5 cts ignored", tx_allow, 1'b1);
    dsr_n_in = 1; step("R5", 4);
    lit("R5 dsr used", tx_allow, 1'b0);
    dsr_n_in = 0; cts_n_in = 0; step("R5", 4);
    cfg_pair_sel = 0;

    // R6 / R7 arming and hysteresis
    sw_rts = 1; rx_level = LVL_W'(50); step("R6", 2);
    lit("R6 not enabled", rts_n_out, 1'b0);
    cfg_auto_req_en = 1; step("R6", 1);
    lit("R6 armed", rts_n_out, 1'b1);
    rx_level = LVL_W'(30); step("R7", 2);
    lit("R7 between", rts_n_out, 1'b1);
    rx_level = LVL_W'(16); step("R7", 1);
    lit("R7 low mark", rts_n_out, 1'b0);
    rx_level = LVL_W'(47); step("R7", 2);
    lit("R7 below high", rts_n_out, 1'b0);
    cfg_auto_req_en = 0; step("R6", 1);

    // R8 / R10 / R11 hold flag
    cfg_irq_master_en = 1; cfg_irq_hold_en = 1;
    cts_n_in = 1; step("R8", 4);
    lit("R8 flag", flag_hold, 1'b1);
    lit("R11 irq", irq, 1'b1);
    cfg_irq_hold_en = 0; step("R11", 1);
    lit("R11 gated", irq, 1'b0);
    cfg_irq_hold_en = 1;
    isr_rd = 1; step("R10", 1); isr_rd = 0;
    lit("R10 cleared", flag_hold, 1'b0);
    cts_n_in = 0; step("R8", 4);

    // R9 request-output flag
    cfg_irq_req_en = 1; sw_rts = 1; step("R9", 2);
    sw_rts = 0; step("R9", 2);
    lit("R9 flag", flag_req, 1'b1);
    msr_rd = 1; step("R10", 1); msr_rd = 0;
    lit("R10 msr clear", flag_req, 1'b0);
    cfg_irq_master_en = 0; sw_rts = 1; step("R9", 1); sw_rts = 0; step("R9", 2);
    lit("R9 master off", flag_req, 1'b0);

    // Random phase
    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      cmp("RND");
      tx_start = 0; tx_stop_done = 0;
      if (m_busy) tx_stop_done = ($urandom_range(0, 7) == 0);
      else if (!m_hold) tx_start = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 5) == 0) cts_n_in = $urandom_range(0, 1);
      if ($urandom_range(0, 5) == 0) dsr_n_in = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) sw_rts = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) sw_dtr = $urandom_range(0, 1);
      if ($urandom_range(0, 49) == 0) cfg_pair_sel = $urandom_range(0, 1);
      if ($urandom_range(0, 29) == 0) cfg_auto_hold_en = $urandom_range(0, 1);
      if ($urandom_range(0, 29) == 0) cfg_auto_req_en = $urandom_range(0, 1);
      if ($urandom_range(0, 29) == 0) cfg_irq_master_en = $urandom_range(0, 1);
      if ($urandom_range(0, 19) == 0) cfg_irq_hold_en = $urandom_range(0, 1);
      if ($urandom_range(0, 19) == 0) cfg_irq_req_en = $urandom_range(0, 1);
      isr_rd = ($urandom_range(0, 15) == 0);
      msr_rd = ($urandom_range(0, 15) == 0);
      rx_level = LVL_W'($urandom_range(0, MAXL));
      if ($urandom_range(0, 199) == 0) begin
        thr_hi = LVL_W'($urandom_range(1, MAXL));
        thr_lo = LVL_W'($urandom_range(0, int'(thr_hi) - 1));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule